// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Each cycle it looks at the register numbers and control flags held in the pipeline registers and decides three things. It sets where each execute-stage ALU operand comes from. It decides whether fetch and decode must hold. It decides which pipeline registers must be cleared.

Branches and jumps resolve in execute. The fetch path always assumes the sequential address, so a control transfer is found late. When execute redirects the PC, the two younger instructions already fetched are discarded by clearing the fetch/decode and decode/execute registers. A load whose result is needed by the instruction right behind it cannot forward in time. The PC and the fetch/decode register then hold for one cycle while a bubble enters execute. After that cycle the load has reached writeback and ordinary forwarding supplies the value.

Top module: `hz_hazard_unit`

## Requirements
- R1: An execute operand whose source register equals the memory-stage destination, with that stage's write enable high and the destination not x0, gets select code 2'b10.
- R2: An execute operand that has no valid memory-stage match but equals a writeback-stage destination (write enable high, destination not x0) gets select code 2'b01.
- R3: When both the memory and writeback stages validly match the same source register, the memory stage wins (code 2'b10).
- R4: A stage whose write enable is low, or whose destination is x0, is never forwarded from; with no valid match the select is 2'b00 (register file).
- R5: Operand A's select depends only on the execute rs1 field and operand B's only on the execute rs2 field.
- R6: If execute holds a load with a non-x0 destination equal to decode rs1 or decode rs2, and no redirect occurs, then pc_hold, fd_hold and dx_flush are high and fd_flush is low.
- R7: A non-load in execute, or a load whose destination is x0, causes no stall.
- R8: The next-PC select is 2'b00 (sequential) unless execute redirects: 2'b01 (PC-relative target) for a branch whose comparison holds or a JAL, and 2'b10 (register target) for a JALR; JALR outranks JAL, which outranks a branch.
- R9: On a redirect, fd_flush and dx_flush are high and pc_hold and fd_hold are low.
- R10: A redirect in the same cycle as a load-use match overrides the stall: no hold is raised.
- R11: With no dependency and no redirect, all hold and flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register |
| ex_rs1 | input | 5 | Execute-stage first source register |
| ex_rs2 | input | 5 | Execute-stage second source register |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_is_branch | input | 1 | Execute-stage instruction is a conditional branch |
| ex_br_cond | input | 1 | Branch comparison outcome from the execute ALU |
| ex_is_jal | input | 1 | Execute-stage instruction is JAL |
| ex_is_jalr | input | 1 | Execute-stage instruction is JALR |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage register write enable |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_we | input | 1 | Writeback-stage register write enable |
| fwd_a_sel | output | 2 | Operand A source: 00 file, 01 writeback, 10 memory |
| fwd_b_sel | output | 2 | Operand B source: 00 file, 01 writeback, 10 memory |
| npc_sel | output | 2 | Next PC: 00 sequential, 01 PC-relative, 10 register |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged |
| fd_flush | output | 1 | Clear the fetch/decode register |
| dx_flush | output | 1 | Clear the decode/execute register |

## Verification
The embedded assertions watch, on every input change, that the select codes stay legal, that a valid memory-stage match always wins, that holds and flushes never contradict each other, and that a redirect never leaves a hold active. What the assertions cannot show is that the right answer is chosen for each combination of register numbers. The bench shows this by comparing every output with an independently computed expectation. It uses crafted cases such as x0 destinations, disabled writes, double matches and a redirect colliding with a load-use match, plus many random register patterns drawn from a narrow range so that matches are frequent.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard controller.
// Assumes: select codes are decoded by the execute-stage operand
// multiplexers and the PC multiplexer exactly as listed here.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_REGFILE  = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_MEM = 2'b10
    } fwd_sel_t;

    typedef enum logic [1:0] {
        NPC_SEQ      = 2'b00,
        NPC_TARGET   = 2'b01,
        NPC_INDIRECT = 2'b10
    } npc_sel_t;
endpackage

// File: rtl/hz_fwd_select.sv
// Operand source selection for one execute-stage operand.
// Compares the operand's source register against the destinations of the
// memory and writeback stages; the memory stage is younger and wins.
// Assumes: register x0 always reads zero and is never a forwarding source.
module hz_fwd_select
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    // Qualify each producer match with its write enable and a non-x0 target.
    always_comb begin
        mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src_reg);
        wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src_reg);
    end

    // Pick the youngest valid producer, else the register file.
    always_comb begin
        if (mem_hit)
            sel = FWD_FROM_MEM;
        else if (wb_hit)
            sel = FWD_FROM_WB;
        else
            sel = FWD_REGFILE;
    end

    // Check the select against the raw stage fields.
    always_comb begin
        if (!$isunknown({src_reg, mem_rd, mem_we, wb_rd, wb_we})) begin
            AST_SEL_LEGAL: assert (sel != 2'b11); // R4
            AST_MEM_WINS: assert (!(mem_we && mem_rd == src_reg && src_reg != ZERO_REG) || sel == FWD_FROM_MEM); // R3
            AST_NO_FWD_X0: assert (src_reg != ZERO_REG || sel == FWD_REGFILE); // R4
        end
    end
endmodule

// File: rtl/hz_load_use.sv
// Load-use dependency detector.
// Raises a stall request when the instruction in execute is a load whose
// destination is read by the instruction in decode.
// Assumes: a load to x0 produces nothing a consumer can depend on.
module hz_load_use #(
    parameter int REG_AW = 5
) (
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    output logic              stall_req
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic rs1_dep;
    logic rs2_dep;

    // Compare each decode source against the load destination.
    always_comb begin
        rs1_dep   = (id_rs1 == ex_rd);
        rs2_dep   = (id_rs2 == ex_rd);
        stall_req = ex_is_load && (ex_rd != ZERO_REG) && (rs1_dep || rs2_dep);
    end

    // A load to x0 or a non-load must never stall.
    always_comb begin
        if (!$isunknown({ex_is_load, ex_rd, id_rs1, id_rs2})) begin
            AST_NO_STALL_NONLOAD: assert (ex_is_load || !stall_req); // R7
            AST_NO_STALL_X0: assert (ex_rd != ZERO_REG || !stall_req); // R7
        end
    end
endmodule

// File: rtl/hz_flow_ctrl.sv
// Next-PC selection and pipeline hold/flush arbitration.
// Resolves the control transfer in execute and merges it with the
// load-use stall request; a redirect outranks the stall because the
// stalled decode instruction lies on the discarded path.
// Assumes: fetch always proceeds sequentially (static not-taken).
module hz_flow_ctrl
    import hz_pkg::*;
(
    input  logic       is_branch,
    input  logic       br_cond,
    input  logic       is_jal,
    input  logic       is_jalr,
    input  logic       stall_req,
    output logic [1:0] npc_sel,
    output logic       pc_hold,
    output logic       fd_hold,
    output logic       fd_flush,
    output logic       dx_flush
);
    logic redirect;

    // Resolve the real next-PC source from the execute instruction type.
    always_comb begin
        if (is_jalr)
            npc_sel = NPC_INDIRECT;
        else if (is_jal || (is_branch && br_cond))
            npc_sel = NPC_TARGET;
        else
            npc_sel = NPC_SEQ;
        redirect = (npc_sel != NPC_SEQ);
    end

    // Arbitrate redirect flush versus load-use stall.
    always_comb begin
        pc_hold  = 1'b0;
        fd_hold  = 1'b0;
        fd_flush = 1'b0;
        dx_flush = 1'b0;
        if (redirect) begin
            fd_flush = 1'b1;
            dx_flush = 1'b1;
        end else if (stall_req) begin
            pc_hold  = 1'b1;
            fd_hold  = 1'b1;
            dx_flush = 1'b1;
        end
    end

    // Holds and flushes must stay mutually consistent.
    always_comb begin
        if (!$isunknown({is_branch, br_cond, is_jal, is_jalr, stall_req})) begin
            AST_HOLD_NOT_FLUSH: assert (!(fd_hold && fd_flush)); // R6
            AST_HOLD_BUBBLE: assert (!pc_hold || dx_flush); // R6
            AST_JALR_INDIRECT: assert (!is_jalr || npc_sel == NPC_INDIRECT); // R8
            AST_REDIRECT_NO_HOLD: assert (!(is_jal || is_jalr) || (!pc_hold && fd_flush)); // R10
        end
    end
endmodule

// File: rtl/hz_hazard_unit.sv
// Hazard controller top for a five-stage in-order pipeline.
// Produces the two execute operand forwarding selects, the next-PC select,
// the PC and fetch/decode holds, and the decode/execute flushes.
// Assumes: all inputs come straight from pipeline registers; the block
// holds no state and settles within the cycle.
module hz_hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_is_load,
    input  logic              ex_is_branch,
    input  logic              ex_br_cond,
    input  logic              ex_is_jal,
    input  logic              ex_is_jalr,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic [1:0]        npc_sel,
    output logic              pc_hold,
    output logic              fd_hold,
    output logic              fd_flush,
    output logic              dx_flush
);
    logic [REG_AW-1:0] op_src [NUM_OPS];
    logic [1:0]        op_sel [NUM_OPS];
    logic              lu_stall;

    // Gather the execute source fields into an operand-indexed array.
    always_comb begin
        for (int i = 0; i < NUM_OPS; i++)
            op_src[i] = '0;
        op_src[0] = ex_rs1;
        op_src[1] = ex_rs2;
    end

    // One selector per execute operand.
    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
            hz_fwd_select #(.REG_AW(REG_AW)) u_sel (
                .src_reg (op_src[g]),
                .mem_rd  (mem_rd),
                .mem_we  (mem_we),
                .wb_rd   (wb_rd),
                .wb_we   (wb_we),
                .sel     (op_sel[g])
            );
        end
    endgenerate

    // Route the per-operand selects to the named outputs.
    always_comb begin
        fwd_a_sel = op_sel[0];
        fwd_b_sel = op_sel[1];
    end

    hz_load_use #(.REG_AW(REG_AW)) u_lu (
        .ex_is_load (ex_is_load),
        .ex_rd      (ex_rd),
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .stall_req  (lu_stall)
    );

    hz_flow_ctrl u_flow (
        .is_branch (ex_is_branch),
        .br_cond   (ex_br_cond),
        .is_jal    (ex_is_jal),
        .is_jalr   (ex_is_jalr),
        .stall_req (lu_stall),
        .npc_sel   (npc_sel),
        .pc_hold   (pc_hold),
        .fd_hold   (fd_hold),
        .fd_flush  (fd_flush),
        .dx_flush  (dx_flush)
    );

    // Cross-module consistency between the stall and redirect paths.
    always_comb begin
        if (!$isunknown({id_rs1, id_rs2, ex_rd, ex_is_load, ex_is_branch,
                         ex_br_cond, ex_is_jal, ex_is_jalr})) begin
            AST_REDIRECT_FLUSH: assert (npc_sel == NPC_SEQ || (fd_flush && dx_flush && !fd_hold)); // R9
            AST_STALL_ONLY_LU: assert (!pc_hold || lu_stall); // R11
            AST_HOLD_PAIR: assert (pc_hold == fd_hold); // R6
        end
    end
endmodule

// File: tb/hz_hazard_unit_tb.sv
module hz_hazard_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N_RANDOM   = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_is_load, ex_is_branch, ex_br_cond, ex_is_jal, ex_is_jalr, mem_we, wb_we;
    logic [1:0] fwd_a_sel, fwd_b_sel, npc_sel;
    logic pc_hold, fd_hold, fd_flush, dx_flush;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    hz_hazard_unit u_dut (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_is_load(ex_is_load), .ex_is_branch(ex_is_branch),
        .ex_br_cond(ex_br_cond), .ex_is_jal(ex_is_jal), .ex_is_jalr(ex_is_jalr),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .npc_sel(npc_sel),
        .pc_hold(pc_hold), .fd_hold(fd_hold), .fd_flush(fd_flush), .dx_flush(dx_flush)
    );

    // Expected operand select from the requirement text.
    function automatic logic [1:0] exp_fwd(input logic [4:0] s, input logic [4:0] mrd,
                                           input logic mwe, input logic [4:0] wrd, input logic wwe);
        if (mwe && mrd != 0 && mrd == s) return 2'b10;
        if (wwe && wrd != 0 && wrd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] exp_npc();
        if (ex_is_jalr) return 2'b10;
        if (ex_is_jal || (ex_is_branch && ex_br_cond)) return 2'b01;
        return 2'b00;
    endfunction

    // {pc_hold, fd_hold, fd_flush, dx_flush}
    function automatic logic [3:0] exp_ctrl();
        logic lu;
        lu = ex_is_load && ex_rd != 0 && (id_rs1 == ex_rd || id_rs2 == ex_rd);
        if (exp_npc() != 2'b00) return 4'b0011;
        if (lu) return 4'b1101;
        return 4'b0000;
    endfunction

    task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "fwd_a_sel", {2'b0, fwd_a_sel}, {2'b0, exp_fwd(ex_rs1, mem_rd, mem_we, wb_rd, wb_we)});
        check(tag, "fwd_b_sel", {2'b0, fwd_b_sel}, {2'b0, exp_fwd(ex_rs2, mem_rd, mem_we, wb_rd, wb_we)});
        check(tag, "npc_sel", {2'b0, npc_sel}, {2'b0, exp_npc()});
        check(tag, "hold/flush", {pc_hold, fd_hold, fd_flush, dx_flush}, exp_ctrl());
    endtask

    task automatic clear_in();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
        {ex_is_load, ex_is_branch, ex_br_cond, ex_is_jal, ex_is_jalr, mem_we, wb_we} = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive on the rising edge, sample on the falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1357));
        clear_in();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        step();
        // R11: idle inputs give no hold, flush or forward
        check("R11", "idle ctrl", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b0000);
        check("R4", "idle fwd_a", {2'b0, fwd_a_sel}, 4'b0000);

        // R1: memory-stage match on operand A
        @(posedge clk); clear_in(); ex_rs1 = 5'd7; mem_rd = 5'd7; mem_we = 1; ex_rs2 = 5'd3; step();
        check("R1", "fwd_a mem", {2'b0, fwd_a_sel}, 4'b0010);
        check("R5", "fwd_b untouched", {2'b0, fwd_b_sel}, 4'b0000);

        // R2: writeback match on operand B
        @(posedge clk); clear_in(); ex_rs2 = 5'd9; wb_rd = 5'd9; wb_we = 1; ex_rs1 = 5'd4; step();
        check("R2", "fwd_b wb", {2'b0, fwd_b_sel}, 4'b0001);
        check("R5", "fwd_a untouched", {2'b0, fwd_a_sel}, 4'b0000);

        // R3: both stages match
        @(posedge clk); clear_in(); ex_rs1 = 5'd12; ex_rs2 = 5'd12; mem_rd = 5'd12; wb_rd = 5'd12;
        mem_we = 1; wb_we = 1; step();
        check("R3", "fwd_a both", {2'b0, fwd_a_sel}, 4'b0010);
        check("R3", "fwd_b both", {2'b0, fwd_b_sel}, 4'b0010);

        // R4: disabled memory write falls to writeback; x0 never forwards
        @(posedge clk); clear_in(); ex_rs1 = 5'd5; mem_rd = 5'd5; wb_rd = 5'd5; wb_we = 1; step();
        check("R4", "mem we low", {2'b0, fwd_a_sel}, 4'b0001);
        @(posedge clk); clear_in(); mem_we = 1; wb_we = 1; step();
        check("R4", "x0 source", {2'b0, fwd_a_sel}, 4'b0000);

        // R6: load followed by use of rs2
        @(posedge clk); clear_in(); ex_is_load = 1; ex_rd = 5'd10; id_rs2 = 5'd10; id_rs1 = 5'd1; step();
        check("R6", "load-use", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b1101);

        // R7: load to x0 and non-load
        @(posedge clk); clear_in(); ex_is_load = 1; ex_rd = 5'd0; step();
        check("R7", "load x0", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b0000);
        @(posedge clk); clear_in(); ex_rd = 5'd6; id_rs1 = 5'd6; step();
        check("R7", "alu no stall", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b0000);

        // R8: branch taken, not taken, JAL, JALR, JALR over JAL
        @(posedge clk); clear_in(); ex_is_branch = 1; ex_br_cond = 1; step();
        check("R8", "branch taken", {2'b0, npc_sel}, 4'b0001);
        check("R9", "branch flush", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b0011);
        @(posedge clk); clear_in(); ex_is_branch = 1; step();
        check("R8", "branch not taken", {2'b0, npc_sel}, 4'b0000);
        @(posedge clk); clear_in(); ex_is_jal = 1; step();
        check("R8", "jal", {2'b0, npc_sel}, 4'b0001);
        @(posedge clk); clear_in(); ex_is_jalr = 1; ex_is_jal = 1; step();
        check("R8", "jalr priority", {2'b0, npc_sel}, 4'b0010);
        check("R9", "jalr flush", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b0011);

        // R10: redirect with a simultaneous load-use match
        @(posedge clk); clear_in(); ex_is_load = 1; ex_rd = 5'd8; id_rs1 = 5'd8;
        ex_is_branch = 1; ex_br_cond = 1; step();
        check("R10", "redirect beats stall", {pc_hold, fd_hold, fd_flush, dx_flush}, 4'b0011);

        // Random patterns over a narrow register range.
        for (int n = 0; n < N_RANDOM; n++) begin
            @(posedge clk);
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            ex_rd  = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
            wb_rd  = 5'($urandom_range(0, 3));
            ex_is_load = 1'($urandom_range(0, 1)); mem_we = 1'($urandom_range(0, 1));
            wb_we = 1'($urandom_range(0, 1)); ex_br_cond = 1'($urandom_range(0, 1));
            ex_is_branch = ($urandom_range(0, 3) == 0);
            ex_is_jal = ($urandom_range(0, 7) == 0);
            ex_is_jalr = ($urandom_range(0, 7) == 0);
            step();
            check_all("random R1/R2/R3/R4/R5/R6/R7/R8/R9/R10/R11");
        end
        finish_run();
    end
endmodule